// File: doc/BRIEF.md
# Sample Rate Ratio Estimator

This block estimates the ratio between a source sample rate and a sink sample rate. Its counting clock is a fast clock locked to the source rate, for example 64 times the source rate. The sink rate arrives as a tick signal from another clock domain. A two-flop synchroniser brings each tick into the fast domain, and an edge detector turns its rising edge into a one-cycle pulse. A counter measures the number of fast-clock cycles between consecutive pulses. One such count is coarse, about 6 bits.

Precision comes from averaging many counts. A running sum over the most recent 2^AVG_LOG2 counts (2048 by default) adds each new count and removes the count that falls out of a delay line. No division is done, so the sum itself is the ratio word. It equals the source-to-sink rate ratio times the averaging depth times the fast-clock multiple. A moving average of this kind also acts as a sinc-shaped low-pass filter on clock jitter. Its first null is at the sink rate divided by the depth, and its attenuation rises at about 20 dB per decade above that.

A resampler downstream uses the ratio word to advance its phase accumulator. It should take the word only while the valid flag is high.

Top module: `rate_ratio_est`

## Requirements
- R1: While reset is asserted, and after it is released until the first measurement completes, `ratio_sum` is 0 and `ratio_valid` is 0.
- R2: `sink_tick` passes through a two-flop synchroniser. Each rising edge of the synchronised tick makes one measurement, equal to the number of `clk_fast` cycles since the previous rising edge. A steady tick period of P fast cycles therefore yields P.
- R3: The first rising edge after reset only starts the counter. It produces no measurement and leaves `ratio_sum` and `ratio_valid` unchanged.
- R4: A measurement saturates at 2^CNT_W-1. A period longer than that yields 2^CNT_W-1.
- R5: Once 2^AVG_LOG2 measurements have been taken, `ratio_sum` equals the exact sum of the most recent 2^AVG_LOG2 measurements. The sum is CNT_W+AVG_LOG2 bits wide and is not divided.
- R6: `ratio_valid` stays 0 until 2^AVG_LOG2 measurements have been taken since reset. It then rises and stays 1 until the next reset.
- R7: `ratio_sum` changes only when a new measurement is taken. While the tick shows no rising edge, the output holds its value.
- R8: While fewer than 2^AVG_LOG2 measurements have been taken, `ratio_sum` equals the sum of all measurements taken since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Counting clock, locked to a multiple of the source rate |
| rst_n | input | 1 | Active-low reset, synchronous to clk_fast |
| sink_tick | input | 1 | Sink-rate tick, asynchronous to clk_fast; its rising edge marks a sink period |
| ratio_sum | output | CNT_W+AVG_LOG2 | Running sum of the most recent measurements (the ratio word) |
| ratio_valid | output | 1 | High once the averaging window is full |

## Verification
The hardest condition to reach is the moment the window wraps. This is the first measurement at which the oldest count must be taken out of the sum. It only happens after the full depth of periods has gone by, and a wrong delay-line address or a subtraction off by one slot shows up only there. The bench builds the averager with a short window, so it passes the wrap many times in a short run. It drives jittered periods with a ±1 cycle dither around a fixed length, and adds one period longer than the saturation limit. The longer period is placed so that it later leaves the window, which forces the subtraction of a saturated count.

// File: rtl/rre_pkg.sv
package rre_pkg;
  // Measurement for a period whose counter shows cnt at the closing edge:
  // one more than the count, clipped to the largest code.
  function automatic int unsigned rre_meas_next(input int unsigned cnt,
                                                input int unsigned maxv);
    return (cnt >= maxv) ? maxv : cnt + 1;
  endfunction

  // Running-sum update: add the newcomer, remove the leaver.
  function automatic longint unsigned rre_sum_next(input longint unsigned sum,
                                                   input longint unsigned add_v,
                                                   input longint unsigned sub_v);
    return sum + add_v - sub_v;
  endfunction
endpackage

// File: rtl/rre_tick_sync.sv
module rre_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= tick_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/rre_period_counter.sv
module rre_period_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_vld_o
);
  localparam int unsigned MAXV = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [CNT_W-1:0] meas_next;
  logic             cnt_full;

  assign cnt_full  = (cnt_q == CNT_W'(MAXV));
  assign meas_next = CNT_W'(rre_pkg::rre_meas_next(32'(cnt_q), MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      meas_o     <= '0;
      meas_vld_o <= 1'b0;
    end else begin
      meas_vld_o <= 1'b0;
      if (rise_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) begin
          meas_o     <= meas_next;
          meas_vld_o <= 1'b1;
        end
      end else if (!cnt_full) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (cnt_q == '0)); // R2
  AST_MEAS_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld_o |-> $past(armed_q)); // R3
  AST_MEAS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld_o |-> (meas_o != '0)); // R4
endmodule

// File: rtl/rre_window_sum.sv
module rre_window_sum #(
  parameter int CNT_W    = 7,
  parameter int AVG_LOG2 = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          in_i,
  input  logic                      in_vld_i,
  output logic [CNT_W+AVG_LOG2-1:0] sum_o,
  output logic                      full_o
);
  localparam int SUM_W = CNT_W + AVG_LOG2;
  localparam int DEPTH = 1 << AVG_LOG2;

  logic [CNT_W-1:0]    line_q [DEPTH];
  logic [AVG_LOG2-1:0] wr_ptr_q;
  logic [AVG_LOG2:0]   fill_q;
  logic [CNT_W-1:0]    leaving;
  logic [SUM_W-1:0]    sum_next;

  assign leaving  = full_o ? line_q[wr_ptr_q] : '0;
  assign sum_next = SUM_W'(rre_pkg::rre_sum_next(64'(sum_o), 64'(in_i), 64'(leaving)));

  always_ff @(posedge clk) begin
    if (in_vld_i) line_q[wr_ptr_q] <= in_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      fill_q   <= '0;
      sum_o    <= '0;
      full_o   <= 1'b0;
    end else if (in_vld_i) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      sum_o    <= sum_next;
      if (!full_o) begin
        fill_q <= fill_q + 1'b1;
        full_o <= (fill_q == (AVG_LOG2+1)'(DEPTH - 1));
      end
    end
  end

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> $stable(sum_o)); // R7
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> full_o); // R6
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= (AVG_LOG2+1)'(DEPTH)); // R6
endmodule

// File: rtl/rate_ratio_est.sv
module rate_ratio_est #(
  parameter int CNT_W    = 7,
  parameter int AVG_LOG2 = 11,
  localparam int SUM_W   = CNT_W + AVG_LOG2
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             sink_tick,
  output logic [SUM_W-1:0] ratio_sum,
  output logic             ratio_valid
);
  logic             tick_rise;
  logic [CNT_W-1:0] meas;
  logic             meas_vld;

  rre_tick_sync sync_i (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .tick_async (sink_tick),
    .rise_o     (tick_rise)
  );

  rre_period_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .rise_i     (tick_rise),
    .meas_o     (meas),
    .meas_vld_o (meas_vld)
  );

  rre_window_sum #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2)) avg_i (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .in_i     (meas),
    .in_vld_i (meas_vld),
    .sum_o    (ratio_sum),
    .full_o   (ratio_valid)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk_fast)
    !rst_n |=> (ratio_sum == '0 && !ratio_valid)); // R1
endmodule

// File: tb/rate_ratio_est_tb_top.sv
module rate_ratio_est_tb_top;
  localparam int CW    = 6;
  localparam int AL    = 5;
  localparam int D     = 1 << AL;
  localparam int SW    = CW + AL;
  localparam int MAXV  = (1 << CW) - 1;
  localparam int NMEAS = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [SW-1:0] ratio_sum;
  logic          ratio_valid;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;
  int            hist [NMEAS+2];
  int            nmeas = 0;

  always #4 clk = ~clk;

  rate_ratio_est #(.CNT_W(CW), .AVG_LOG2(AL)) dut_i (
    .clk_fast    (clk),
    .rst_n       (rst_n),
    .sink_tick   (tick),
    .ratio_sum   (ratio_sum),
    .ratio_valid (ratio_valid)
  );

  function automatic int clip_period(input int p);
    return (p > MAXV) ? MAXV : p;
  endfunction

  function automatic int model_sum(input int n);
    int s = 0;
    for (int i = (n > D ? n - D : 0); i < n; i++) s += hist[i];
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One tick period of p fast cycles; outputs are sampled 6 cycles after the rise.
  task automatic tick_period(input int p, input string req);
    tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
    check({req, " sum"}, int'(ratio_sum), model_sum(nmeas));
    check({req, " valid"}, int'(ratio_valid), (nmeas >= D) ? 1 : 0);
    repeat (p - 6) @(negedge clk);
  endtask

  initial begin
    int prev_p;
    int p;
    int held;
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    check("R1 reset sum", int'(ratio_sum), 0);
    check("R1 reset valid", int'(ratio_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 post-reset sum", int'(ratio_sum), 0);
    // First rise only arms the counter (R3).
    prev_p = 20;
    tick_period(prev_p, "R3 arm");
    for (int i = 0; i < NMEAS; i++) begin
      hist[nmeas] = clip_period(prev_p);
      nmeas++;
      if (i == 10) p = 100;               // R4 saturation, leaves window later
      else if (i == 11) p = MAXV;         // exactly the limit
      else p = 20 + int'($urandom_range(2)) - 1;
      if (nmeas < D) tick_period(p, "R8 partial");
      else if (nmeas == D) tick_period(p, "R6 fill");
      else if (nmeas == 12 + D) tick_period(p, "R4 saturated count leaves");
      else tick_period(p, "R5 window R2");
      prev_p = p;
    end
    // Idle: no rising edge, output must hold (R7).
    held = int'(ratio_sum);
    repeat (40) @(negedge clk);
    check("R7 hold", int'(ratio_sum), held);
    check("R6 sticky", int'(ratio_valid), 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule